// File: doc/BRIEF.md
# Peripheral Register Bank with Set/Clear Write Aliases

This block is the register bank between a simple synchronous peripheral bus and a device core. Software reaches it through an 8-bit byte address, a 32-bit data path, and single-cycle write and read strobes. The device core sees the bank's contents as parallel wires and can load any of the control registers in one clock.

Each control register has three write addresses. The plain address stores the written word. The set address turns on the bits that are 1 in the word. The clear address turns off the bits that are 1 in the word. Because of this, software can change individual bits with one bus write and never needs a read-modify-write sequence.

Some reads change state. The event register latches one-cycle pulses from the core and is emptied when it is read. The FIFO head register drops its entry when it is read, so the next entry appears without a separate command. A FIFO status word reports the fill level and a sticky underflow flag. No field crosses a word boundary, so every field moves in a single bus cycle.

Top module: `alias_regfile`

## Requirements
- R1: A write to word index k (k < N_CTRL, byte address 4*k) replaces control register k with wdata_i. A read strobe returns data on rdata_o after the next rising edge. rdata_o holds its value when rd_i is low. A read of any of the three aliases of register k returns that register.
- R2: A write to word index 8+k (byte 0x20+4*k) ORs wdata_i into control register k.
- R3: A write to word index 16+k (byte 0x40+4*k) clears every bit of control register k where wdata_i is 1.
- R4: When hw_we_i[k] is high, register k loads slice k of hw_wdata_i in that clock. This wins over any bus write to the same register in the same cycle. Any number of registers can load at once, and ctrl_o always shows all of them.
- R5: A read of word index 24 (byte 0x60) returns status_i as sampled at the read strobe.
- R6: A one-cycle pulse on evt_i[b] sets bit b of the event register (word 25, byte 0x64). A read returns the latched bits and then clears them.
- R7: If an evt_i pulse arrives in the same cycle as a read of the event register, that bit is still set after the read.
- R8: fifo_push_i appends fifo_data_i. A read of word 26 (byte 0x68) returns the oldest entry and removes it. Word 27 (byte 0x6C) returns the fill level in bits [LVL_W-1:0].
- R9: A head read while the FIFO is empty returns 0 and removes nothing. It also sets bit 31 of word 27, and that bit clears when word 27 is read.
- R10: A push while the FIFO is full and not being read is dropped. fifo_full_o and fifo_empty_o report the fill state.
- R11: Writes to indices 24..27, to unused indices, or to addresses with addr_i[1:0] != 0 change nothing. Reads of unused indices or of misaligned addresses return 0.
- R12: After reset all control registers, the event register, the underflow flag and rdata_o are 0, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Bus byte address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| ctrl_o | output | N_CTRL*32 | All control registers, register k in slice k |
| hw_we_i | input | N_CTRL | Core load enable, one bit per control register |
| hw_wdata_i | input | N_CTRL*32 | Core load value, one slice per register |
| status_i | input | 32 | Live status word from the core |
| evt_i | input | EVT_W | One-cycle event pulses from the core |
| fifo_push_i | input | 1 | Core pushes a FIFO entry |
| fifo_data_i | input | 32 | Entry to push |
| fifo_full_o | output | 1 | FIFO is full |
| fifo_empty_o | output | 1 | FIFO is empty |

## Verification
The hardest case to reach is a collision between a read side effect and a hardware event in one cycle. Examples are an event pulse landing on the exact edge where the event register is read, and a core load landing on the same register that a bus write targets. The stimulus drives the pulse or the load in the same clock as the bus strobe. It then reads again to show that the bit or value survived. Random sequences mix alias writes, pushes, head reads on an empty FIFO, and event reads that carry random pulses, so these collisions also occur without being planned.

// File: rtl/regf_pkg.sv
`timescale 1ns/1ps
package regf_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned AW        = 8;
  localparam int unsigned IW        = AW - 2;
  localparam int unsigned SET_BASE  = 8;
  localparam int unsigned CLR_BASE  = 16;
  localparam int unsigned STAT_IDX  = 24;
  localparam int unsigned EVT_IDX   = 25;
  localparam int unsigned HEAD_IDX  = 26;
  localparam int unsigned FSTAT_IDX = 27;
  localparam int unsigned UNF_BIT   = 31;

  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_PLAIN = 2'd1,
    WK_SET   = 2'd2,
    WK_CLR   = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/regf_decode.sv
`timescale 1ns/1ps
module regf_decode
  import regf_pkg::*;
#(
  parameter int unsigned N_CTRL = 4
) (
  input  logic [AW-1:0]     addr_i,
  output logic [N_CTRL-1:0] plain_o,
  output logic [N_CTRL-1:0] set_o,
  output logic [N_CTRL-1:0] clr_o,
  output logic              stat_o,
  output logic              evt_o,
  output logic              head_o,
  output logic              fstat_o
);
  logic          aligned;
  logic [IW-1:0] idx;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign idx     = addr_i[AW-1:2];

  for (genvar k = 0; k < N_CTRL; k++) begin : g_sel
    assign plain_o[k] = aligned && (idx == IW'(k));
    assign set_o[k]   = aligned && (idx == IW'(SET_BASE + k));
    assign clr_o[k]   = aligned && (idx == IW'(CLR_BASE + k));
  end

  assign stat_o  = aligned && (idx == IW'(STAT_IDX));
  assign evt_o   = aligned && (idx == IW'(EVT_IDX));
  assign head_o  = aligned && (idx == IW'(HEAD_IDX));
  assign fstat_o = aligned && (idx == IW'(FSTAT_IDX));
endmodule

// File: rtl/regf_ctrl_reg.sv
`timescale 1ns/1ps
module regf_ctrl_reg
  import regf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  wr_kind_e      kind_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          hw_we_i,
  input  logic [DW-1:0] hw_wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (hw_we_i) begin
      q <= hw_wdata_i; // core wins
    end else begin
      unique case (kind_i)
        WK_PLAIN: q <= wdata_i;
        WK_SET:   q <= q | wdata_i;
        WK_CLR:   q <= q & ~wdata_i;
        default:  q <= q;
      endcase
    end
  end

  assign q_o = q;
endmodule

// File: rtl/regf_sticky.sv
`timescale 1ns/1ps
module regf_sticky #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // a pulse in the clearing cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (clr_i ? '0 : q) | set_i;
  end

  assign q_o = q;
endmodule

// File: rtl/regf_fifo.sv
`timescale 1ns/1ps
module regf_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    din_i,
  input  logic             pop_i,
  output logic [DW-1:0]    dout_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [LVL_W-1:0] level_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [LVL_W-1:0] cnt;
  logic             do_pop, do_push;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == LVL_W'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      cnt <= cnt + LVL_W'(1);
      else if (do_pop && !do_push) cnt <= cnt - LVL_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= din_i;
  end

  assign dout_o  = mem[rp];
  assign level_o = cnt;
endmodule

// File: rtl/alias_regfile.sv
`timescale 1ns/1ps
module alias_regfile
  import regf_pkg::*;
#(
  parameter int unsigned N_CTRL     = 4,
  parameter int unsigned EVT_W      = 16,
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           addr_i,
  input  logic                 wr_i,
  input  logic [31:0]          wdata_i,
  input  logic                 rd_i,
  output logic [31:0]          rdata_o,
  output logic [N_CTRL*32-1:0] ctrl_o,
  input  logic [N_CTRL-1:0]    hw_we_i,
  input  logic [N_CTRL*32-1:0] hw_wdata_i,
  input  logic [31:0]          status_i,
  input  logic [EVT_W-1:0]     evt_i,
  input  logic                 fifo_push_i,
  input  logic [31:0]          fifo_data_i,
  output logic                 fifo_full_o,
  output logic                 fifo_empty_o
);
  localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1);

  logic [N_CTRL-1:0] sel_plain, sel_set, sel_clr;
  logic              sel_stat, sel_evt, sel_head, sel_fstat;
  logic [DW-1:0]     ctrl_q [N_CTRL];
  logic [EVT_W-1:0]  evt_q;
  logic              unf_q;
  logic [DW-1:0]     head;
  logic [LVL_W-1:0]  level;
  logic              rd_evt, rd_head, rd_fstat, underflow;
  logic [DW-1:0]     rd_val, rdata_q;

  regf_decode #(.N_CTRL(N_CTRL)) u_dec (
    .addr_i (addr_i),
    .plain_o(sel_plain),
    .set_o  (sel_set),
    .clr_o  (sel_clr),
    .stat_o (sel_stat),
    .evt_o  (sel_evt),
    .head_o (sel_head),
    .fstat_o(sel_fstat)
  );

  for (genvar k = 0; k < N_CTRL; k++) begin : g_ctrl
    wr_kind_e kind;
    always_comb begin
      kind = WK_NONE;
      if (wr_i) begin
        if (sel_plain[k])    kind = WK_PLAIN;
        else if (sel_set[k]) kind = WK_SET;
        else if (sel_clr[k]) kind = WK_CLR;
      end
    end
    regf_ctrl_reg u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .kind_i    (kind),
      .wdata_i   (wdata_i),
      .hw_we_i   (hw_we_i[k]),
      .hw_wdata_i(hw_wdata_i[k*DW +: DW]),
      .q_o       (ctrl_q[k])
    );
    assign ctrl_o[k*DW +: DW] = ctrl_q[k];
  end

  assign rd_evt    = rd_i && sel_evt;
  assign rd_head   = rd_i && sel_head;
  assign rd_fstat  = rd_i && sel_fstat;
  assign underflow = rd_head && fifo_empty_o;

  regf_sticky #(.W(EVT_W)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_i),
    .clr_i (rd_evt),
    .q_o   (evt_q)
  );

  regf_sticky #(.W(1)) u_unf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (underflow),
    .clr_i (rd_fstat),
    .q_o   (unf_q)
  );

  regf_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (fifo_push_i),
    .din_i  (fifo_data_i),
    .pop_i  (rd_head),
    .dout_o (head),
    .empty_o(fifo_empty_o),
    .full_o (fifo_full_o),
    .level_o(level)
  );

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < N_CTRL; k++) begin
      if (sel_plain[k] || sel_set[k] || sel_clr[k]) rd_val = ctrl_q[k];
    end
    if (sel_stat) rd_val = status_i;
    if (sel_evt)  rd_val = DW'(evt_q);
    if (sel_head) rd_val = fifo_empty_o ? '0 : head;
    if (sel_fstat) begin
      rd_val[LVL_W-1:0] = level;
      rd_val[UNF_BIT]   = unf_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/regf_checker.sv
`timescale 1ns/1ps
module regf_checker #(
  parameter int unsigned N_CTRL = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [7:0]           addr_i,
  input logic                 wr_i,
  input logic [31:0]          wdata_i,
  input logic                 rd_i,
  input logic [31:0]          rdata_o,
  input logic [N_CTRL*32-1:0] ctrl_o,
  input logic [N_CTRL-1:0]    hw_we_i,
  input logic [N_CTRL*32-1:0] hw_wdata_i,
  input logic                 fifo_empty_o
);
  for (genvar k = 0; k < N_CTRL; k++) begin : g_chk
    AST_PLAIN_REPLACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && addr_i == 8'(4*k) && !hw_we_i[k] |=> ctrl_o[k*32 +: 32] == $past(wdata_i)); // R1
    AST_SET_ORS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && addr_i == 8'(32 + 4*k) && !hw_we_i[k]
      |=> ctrl_o[k*32 +: 32] == ($past(ctrl_o[k*32 +: 32]) | $past(wdata_i))); // R2
    AST_CLEAR_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && addr_i == 8'(64 + 4*k) && !hw_we_i[k]
      |=> ctrl_o[k*32 +: 32] == ($past(ctrl_o[k*32 +: 32]) & ~$past(wdata_i))); // R3
    AST_CORE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_we_i[k] |=> ctrl_o[k*32 +: 32] == $past(hw_wdata_i[k*32 +: 32])); // R4
  end

  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R1
  AST_EMPTY_HEAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == 8'h68 && fifo_empty_o |=> rdata_o == 32'h0); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (addr_i[1:0] != 2'b00 || addr_i >= 8'h70) |=> rdata_o == 32'h0); // R11
endmodule

bind alias_regfile regf_checker #(.N_CTRL(N_CTRL)) u_regf_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .rd_i        (rd_i),
  .rdata_o     (rdata_o),
  .ctrl_o      (ctrl_o),
  .hw_we_i     (hw_we_i),
  .hw_wdata_i  (hw_wdata_i),
  .fifo_empty_o(fifo_empty_o)
);

// File: tb/alias_regfile_bench.sv
`timescale 1ns/1ps
module alias_regfile_bench;
  localparam int N = 4, EW = 16, DEPTH = 8, LW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    addr_i = '0;
  logic          wr_i = 1'b0, rd_i = 1'b0;
  logic [31:0]   wdata_i = '0, rdata_o;
  logic [N*32-1:0] ctrl_o, hw_wdata_i = '0;
  logic [N-1:0]  hw_we_i = '0;
  logic [31:0]   status_i = '0;
  logic [EW-1:0] evt_i = '0;
  logic          fifo_push_i = 1'b0;
  logic [31:0]   fifo_data_i = '0;
  logic          fifo_full_o, fifo_empty_o;

  always #4 clk = ~clk;

  alias_regfile #(.N_CTRL(N), .EVT_W(EW), .FIFO_DEPTH(DEPTH)) u_alias_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rd_i(rd_i), .rdata_o(rdata_o), .ctrl_o(ctrl_o), .hw_we_i(hw_we_i),
    .hw_wdata_i(hw_wdata_i), .status_i(status_i), .evt_i(evt_i),
    .fifo_push_i(fifo_push_i), .fifo_data_i(fifo_data_i),
    .fifo_full_o(fifo_full_o), .fifo_empty_o(fifo_empty_o)
  );

  int n_chk = 0, n_err = 0;
  bit reported = 0;
  logic [31:0]   m_ctrl [N];
  logic [EW-1:0] m_evt;
  logic [31:0]   m_q [$];
  logic          m_unf;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic logic [31:0] exp_read(logic [7:0] a);
    int i;
    logic [31:0] r;
    r = '0;
    if (a[1:0] != 2'b00) return '0;
    i = int'(a[7:2]);
    if (i < N) r = m_ctrl[i];
    else if (i >= 8 && i < 8 + N) r = m_ctrl[i-8];
    else if (i >= 16 && i < 16 + N) r = m_ctrl[i-16];
    else if (i == 24) r = status_i;
    else if (i == 25) r = 32'(m_evt);
    else if (i == 26) r = (m_q.size() == 0) ? '0 : m_q[0];
    else if (i == 27) begin
      r[LW-1:0] = LW'(m_q.size());
      r[31] = m_unf;
    end
    return r;
  endfunction

  function automatic void model_write(logic [7:0] a, logic [31:0] d);
    int i;
    if (a[1:0] != 2'b00) return;
    i = int'(a[7:2]);
    if (i < N) m_ctrl[i] = d;
    else if (i >= 8 && i < 8 + N) m_ctrl[i-8] |= d;
    else if (i >= 16 && i < 16 + N) m_ctrl[i-16] &= ~d;
  endfunction

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_rd(logic [7:0] a, logic [EW-1:0] ev, string tag);
    logic [31:0] e;
    @(negedge clk); e = exp_read(a); addr_i = a; rd_i = 1'b1; evt_i = ev;
    @(negedge clk); rd_i = 1'b0; evt_i = '0;
    if (a == 8'h64) m_evt = '0;
    if (a == 8'h68) begin
      if (m_q.size() == 0) m_unf = 1'b1;
      else void'(m_q.pop_front());
    end
    if (a == 8'h6C) m_unf = 1'b0;
    m_evt |= ev;
    chk(tag, rdata_o, e);
  endtask

  task automatic push(logic [31:0] d);
    @(negedge clk); fifo_push_i = 1'b1; fifo_data_i = d;
    @(negedge clk); fifo_push_i = 1'b0;
    if (m_q.size() < DEPTH) m_q.push_back(d);
  endtask

  task automatic chk_ctrl(string tag);
    for (int k = 0; k < N; k++) chk(tag, ctrl_o[k*32 +: 32], m_ctrl[k]);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < N; k++) m_ctrl[k] = '0;
    m_evt = '0; m_unf = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 rdata", rdata_o, 32'h0);
    chk_ctrl("R12 ctrl");
    chk("R12 empty", 32'(fifo_empty_o), 32'h1);
    bus_rd(8'h64, '0, "R12 evt");
    bus_rd(8'h6C, '0, "R12 fstat");

    // R1 plain
    bus_wr(8'h08, 32'hA5A5_0F0F);
    chk_ctrl("R1 plain write");
    bus_rd(8'h08, '0, "R1 plain read");
    bus_rd(8'h28, '0, "R1 set-alias read");
    @(negedge clk);
    chk("R1 hold", rdata_o, 32'hA5A5_0F0F);
    // R2 set, R3 clear
    bus_wr(8'h28, 32'h0000_F0F0);
    chk_ctrl("R2 set");
    bus_wr(8'h48, 32'hA000_00FF);
    chk_ctrl("R3 clear");
    bus_rd(8'h48, '0, "R3 read");

    // R4 core vs bus same cycle
    @(negedge clk); addr_i = 8'h04; wdata_i = 32'h1111_1111; wr_i = 1'b1;
    hw_we_i = 4'b0010; hw_wdata_i[32 +: 32] = 32'hCAFE_0001;
    @(negedge clk); wr_i = 1'b0; hw_we_i = '0;
    m_ctrl[1] = 32'hCAFE_0001;
    chk_ctrl("R4 core wins");
    @(negedge clk);
    for (int k = 0; k < N; k++) hw_wdata_i[k*32 +: 32] = 32'h5000_0000 + 32'(k);
    hw_we_i = '1;
    @(negedge clk); hw_we_i = '0;
    for (int k = 0; k < N; k++) m_ctrl[k] = 32'h5000_0000 + 32'(k);
    chk_ctrl("R4 all at once");

    // R5 status
    status_i = 32'h1234_5678;
    bus_rd(8'h60, '0, "R5 status");

    // R6 sticky
    @(negedge clk); evt_i = 16'h0008; @(negedge clk); evt_i = '0; m_evt |= 16'h0008;
    bus_rd(8'h64, '0, "R6 capture");
    bus_rd(8'h64, '0, "R6 cleared");
    // R7 collision
    @(negedge clk); evt_i = 16'h0020; @(negedge clk); evt_i = '0; m_evt |= 16'h0020;
    bus_rd(8'h64, 16'h0020, "R7 read with pulse");
    bus_rd(8'h64, '0, "R7 kept");
    bus_rd(8'h64, '0, "R7 then cleared");

    // R8 fifo
    push(32'hAAAA_0001); push(32'hAAAA_0002); push(32'hAAAA_0003);
    bus_rd(8'h6C, '0, "R8 level");
    for (int i = 0; i < 3; i++) bus_rd(8'h68, '0, "R8 head pop");
    // R9 underflow
    bus_rd(8'h68, '0, "R9 empty head");
    chk("R9 still empty", 32'(fifo_empty_o), 32'h1);
    bus_rd(8'h6C, '0, "R9 underflow flag");
    bus_rd(8'h6C, '0, "R9 flag cleared");
    // R10 overflow
    for (int i = 0; i < DEPTH + 1; i++) push(32'hB000_0000 + 32'(i));
    chk("R10 full", 32'(fifo_full_o), 32'h1);
    bus_rd(8'h6C, '0, "R10 level");
    for (int i = 0; i < DEPTH; i++) bus_rd(8'h68, '0, "R10 drained order");
    chk("R10 empty", 32'(fifo_empty_o), 32'h1);

    // R11 ignored writes and unmapped reads
    bus_wr(8'h60, 32'hFFFF_FFFF); bus_wr(8'h64, 32'hFFFF_FFFF);
    bus_wr(8'h70, 32'hFFFF_FFFF); bus_wr(8'h01, 32'hFFFF_FFFF);
    bus_wr(8'h10, 32'hFFFF_FFFF); bus_wr(8'h6C, 32'hFFFF_FFFF);
    chk_ctrl("R11 writes ignored");
    bus_rd(8'h64, '0, "R11 evt untouched");
    bus_rd(8'h6C, '0, "R11 fstat untouched");
    bus_rd(8'h70, '0, "R11 unmapped");
    bus_rd(8'h02, '0, "R11 misaligned");
    bus_rd(8'h10, '0, "R11 gap");

    // random mix
    for (int it = 0; it < 500; it++) begin
      logic [7:0] a;
      a = 8'(((($urandom % 3) * 8) + ($urandom % N)) * 4);
      case ($urandom % 7)
        0: begin bus_wr(a, $urandom); chk_ctrl("R1 R2 R3 random write"); end
        1: bus_rd(a, '0, "R1 random read");
        2: push($urandom);
        3: bus_rd(8'h68, '0, "R8 R9 random head");
        4: bus_rd(8'h64, EW'($urandom), "R6 R7 random evt");
        5: bus_rd(8'h6C, EW'($urandom), "R8 R9 random fstat");
        default: begin status_i = $urandom; bus_rd(8'h60, '0, "R5 random status"); end
      endcase
    end
    report();
  end
endmodule